// File: doc/BRIEF.md
# Overlapping-Window Integer Register File

This block is the integer register file of a 32-bit RISC core whose registers are arranged as a ring of overlapping windows. Each clock, the core sees 32 architectural registers. Eight of them are globals shared by every window. The other 24 come from the current window, which is selected by a current-window pointer. A procedure call moves the pointer down one window and a return moves it back up. Because neighbouring windows share eight physical registers, the values a caller places in its outgoing registers show up in the callee's incoming registers without being copied.

The block holds the window pointer and a window-invalid mask. It carries out the four pointer moves: call-side save, return-side restore, trap entry and trap return. When a save or return would land on a window that the mask marks invalid, the move is refused and a one-cycle overflow or underflow pulse is raised, together with the window number that was attempted. The block has two combinational read ports, which always look through the current window, and one write port. The write port can address either the current window or the window that is current after this cycle's pointer move, so a save or restore can also write its result into the new frame. The window count is a parameter.

Top module: `regwin_file`

## Requirements
- R1: After reset the window pointer is 0, the invalid mask is 0, every register reads as 0, and neither fault pulse is high.
- R2: Architectural numbers 0-7 select globals that are common to all windows. 8-15 select outs, 16-23 select locals private to the window, and 24-31 select ins.
- R3: The out registers of window w are the same storage as the in registers of window (w-1) mod N. The outs of window 0 are therefore the ins of window N-1.
- R4: The op input is decoded as 0 none, 1 save, 2 restore, 3 trap entry and 4 trap return; codes 5-7 do nothing. Save and trap entry move the pointer to (p-1) mod N. Restore and trap return move it to (p+1) mod N. The new pointer is visible in the cycle after the op.
- R5: Architectural register 0 always reads 0, and writes to it are discarded.
- R6: A save whose target window has its mask bit set leaves the pointer unchanged. In the next cycle it gives a one-cycle overflow pulse with fault_win equal to the target window.
- R7: A restore or trap return whose target window has its mask bit set leaves the pointer unchanged. In the next cycle it gives a one-cycle underflow pulse with fault_win equal to the target window.
- R8: Trap entry always moves the pointer and never raises a fault, whatever the mask holds.
- R9: With wr_next_win=1 the write lands in the window that is current after this cycle's move, or in the current window if the move faults. With wr_next_win=0 it lands in the current window. Reads use the current window and see a write from the next cycle on.
- R10: A mask write takes bit i of wim_wdata for window i. Bits at or above N are dropped and read as 0. The new mask governs ops from the next cycle on, and a zero mask never produces a fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Pointer move code (R4) |
| wim_we | input | 1 | Load the invalid mask this cycle |
| wim_wdata | input | 32 | New invalid mask, one bit per window |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural register to write |
| wr_data | input | 32 | Write data |
| wr_next_win | input | 1 | Write through the post-move window |
| rd_a_addr | input | 5 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 5 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| cwp | output | 5 | Current window pointer |
| wim_q | output | 32 | Current invalid mask |
| ovf | output | 1 | Window overflow pulse |
| unf | output | 1 | Window underflow pulse |
| fault_win | output | 5 | Window a faulting move attempted |

## Verification
A wrong window pointer appears on cwp in the cycle after the move that caused it. It also shows on the next read of any out, local or in register, because that read lands in another window's storage. A wrong overlap offset or write-window choice stays hidden until the aliased register is read from the other side of a save or restore, so the bench follows each such write with reads across the move. A stale or mis-masked invalid mask shows only when a move reaches the marked window. The bench steers moves onto the mask bit and compares cwp, the pulses and fault_win every cycle against a behavioural model.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
   localparam int ARCH_W    = 5;
   localparam int NGLOBAL   = 8;
   localparam int WIN_SLOTS = 16;

   typedef enum logic [2:0] {
      WOP_NONE     = 3'd0,
      WOP_SAVE     = 3'd1,
      WOP_RESTORE  = 3'd2,
      WOP_TRAP_IN  = 3'd3,
      WOP_TRAP_RET = 3'd4
   } win_op_e;
endpackage

// File: rtl/regwin_ptr.sv
module regwin_ptr #(
   parameter int NWIN = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  op,
   input  logic        wim_we,
   input  logic [31:0] wim_wdata,
   output logic [4:0]  cwp,
   output logic [4:0]  cwp_nxt,
   output logic [31:0] wim_q,
   output logic        ovf,
   output logic        unf,
   output logic [4:0]  fault_win
);
   import regwin_pkg::*;

   localparam logic [63:0] MASK64   = (64'd1 << NWIN) - 64'd1;
   localparam logic [31:0] WIM_MASK = MASK64[31:0];
   localparam logic [4:0]  LAST_WIN = 5'(NWIN - 1);

   logic [4:0] win_dn, win_up, target;
   logic       ovf_c, unf_c;

   generate
      if (NWIN == 32) begin : g_wrap_nat
         assign win_dn = cwp - 5'd1;
         assign win_up = cwp + 5'd1;
      end else begin : g_wrap_cmp
         assign win_dn = (cwp == 5'd0)     ? LAST_WIN : cwp - 5'd1;
         assign win_up = (cwp == LAST_WIN) ? 5'd0     : cwp + 5'd1;
      end
   endgenerate

   always_comb begin
      cwp_nxt = cwp;
      target  = cwp;
      ovf_c   = 1'b0;
      unf_c   = 1'b0;
      case (op)
         WOP_SAVE: begin
            target = win_dn;
            if (wim_q[win_dn]) ovf_c   = 1'b1;
            else               cwp_nxt = win_dn;
         end
         WOP_TRAP_IN: begin
            target  = win_dn;
            cwp_nxt = win_dn;
         end
         WOP_RESTORE, WOP_TRAP_RET: begin
            target = win_up;
            if (wim_q[win_up]) unf_c   = 1'b1;
            else               cwp_nxt = win_up;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cwp       <= '0;
         wim_q     <= '0;
         ovf       <= 1'b0;
         unf       <= 1'b0;
         fault_win <= '0;
      end else begin
         cwp <= cwp_nxt;
         ovf <= ovf_c;
         unf <= unf_c;
         if (ovf_c || unf_c) fault_win <= target;
         if (wim_we) wim_q <= wim_wdata & WIM_MASK;
      end
   end
endmodule

// File: rtl/regwin_map.sv
module regwin_map #(
   parameter int NWIN = 8,
   parameter int PW   = 8
) (
   input  logic [4:0]    win,
   input  logic [4:0]    arch,
   output logic [PW-1:0] phys
);
   import regwin_pkg::*;

   localparam logic [4:0] LAST_WIN = 5'(NWIN - 1);

   logic [4:0]    win_below;
   logic [PW-1:0] base_cur, base_below, lane;

   assign win_below  = (win == 5'd0) ? LAST_WIN : win - 5'd1;
   assign base_cur   = PW'(NGLOBAL) + PW'({win, 4'b0000});
   assign base_below = PW'(NGLOBAL) + PW'({win_below, 4'b0000});
   assign lane       = PW'(arch[2:0]);

   always_comb begin
      case (arch[4:3])
         2'd0:    phys = PW'(arch);
         2'd1:    phys = base_below + PW'(8) + lane;
         2'd2:    phys = base_cur + lane;
         default: phys = base_cur + PW'(8) + lane;
      endcase
   end
endmodule

// File: rtl/regwin_array.sv
module regwin_array #(
   parameter int DW    = 32,
   parameter int NPHYS = 136,
   parameter int PW    = 8,
   parameter int NRD   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [PW-1:0]            wr_idx,
   input  logic [DW-1:0]            wr_data,
   input  logic [NRD-1:0][PW-1:0]   rd_idx,
   output logic [NRD-1:0][DW-1:0]   rd_data
);
   logic [DW-1:0] cells [1:NPHYS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 1; i < NPHYS; i++) cells[i] <= '0;
      end else if (wr_en && wr_idx != '0) begin
         cells[wr_idx] <= wr_data;
      end
   end

   generate
      for (genvar g = 0; g < NRD; g++) begin : g_rd
         assign rd_data[g] = (rd_idx[g] == '0) ? '0 : cells[rd_idx[g]];
      end
   endgenerate
endmodule

// File: rtl/regwin_file.sv
module regwin_file #(
   parameter int NWIN = 8,
   parameter int DW   = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    op,
   input  logic          wim_we,
   input  logic [31:0]   wim_wdata,
   input  logic          wr_en,
   input  logic [4:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_next_win,
   input  logic [4:0]    rd_a_addr,
   output logic [DW-1:0] rd_a_data,
   input  logic [4:0]    rd_b_addr,
   output logic [DW-1:0] rd_b_data,
   output logic [4:0]    cwp,
   output logic [31:0]   wim_q,
   output logic          ovf,
   output logic          unf,
   output logic [4:0]    fault_win
);
   import regwin_pkg::*;

   localparam int NPHYS = NGLOBAL + WIN_SLOTS * NWIN;
   localparam int PW    = $clog2(NPHYS);
   localparam int NRD   = 2;

   generate
      if (NWIN < 2 || NWIN > 32) begin : g_bad_nwin
         $error("regwin_file: NWIN must lie in 2..32");
      end
      if (DW < 1) begin : g_bad_dw
         $error("regwin_file: DW must be positive");
      end
   endgenerate

   logic [4:0]                cwp_nxt, wr_win;
   logic [NRD-1:0][4:0]       rd_arch;
   logic [NRD-1:0][PW-1:0]    rd_idx;
   logic [NRD-1:0][DW-1:0]    rd_data;
   logic [PW-1:0]             wr_idx;

   regwin_ptr #(.NWIN(NWIN)) ptr_i (
      .clk(clk), .rst_n(rst_n), .op(op),
      .wim_we(wim_we), .wim_wdata(wim_wdata),
      .cwp(cwp), .cwp_nxt(cwp_nxt), .wim_q(wim_q),
      .ovf(ovf), .unf(unf), .fault_win(fault_win)
   );

   assign rd_arch[0] = rd_a_addr;
   assign rd_arch[1] = rd_b_addr;
   assign rd_a_data  = rd_data[0];
   assign rd_b_data  = rd_data[1];
   assign wr_win     = wr_next_win ? cwp_nxt : cwp;

   generate
      for (genvar g = 0; g < NRD; g++) begin : g_rd_map
         regwin_map #(.NWIN(NWIN), .PW(PW)) map_i (
            .win(cwp), .arch(rd_arch[g]), .phys(rd_idx[g])
         );
      end
   endgenerate

   regwin_map #(.NWIN(NWIN), .PW(PW)) wr_map_i (
      .win(wr_win), .arch(wr_addr), .phys(wr_idx)
   );

   regwin_array #(.DW(DW), .NPHYS(NPHYS), .PW(PW), .NRD(NRD)) array_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data)
   );
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
   parameter int NWIN = 8,
   parameter int DW   = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    op,
   input logic [4:0]    cwp,
   input logic [31:0]   wim_q,
   input logic          ovf,
   input logic          unf,
   input logic [4:0]    fault_win,
   input logic [4:0]    rd_a_addr,
   input logic [DW-1:0] rd_a_data,
   input logic [4:0]    rd_b_addr,
   input logic [DW-1:0] rd_b_data
);
   function automatic logic [4:0] below(input logic [4:0] w);
      return (w == 5'd0) ? 5'(NWIN - 1) : w - 5'd1;
   endfunction

   function automatic logic [4:0] above(input logic [4:0] w);
      return (int'(w) == NWIN - 1) ? 5'd0 : w + 5'd1;
   endfunction

   // R4
   cwp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cwp) < NWIN);

   // R4
   save_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 3'd1) |=> (ovf || cwp == below($past(cwp))));

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> (cwp == $past(cwp) && fault_win == below($past(cwp))));

   // R7
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf |-> (cwp == $past(cwp) && fault_win == above($past(cwp))));

   // R6
   fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ovf, unf}));

   // R8
   trap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 3'd3) |=> (!ovf && !unf && cwp == below($past(cwp))));

   // R5
   zero_read_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_addr == 5'd0) |-> (rd_a_data == '0));

   // R5
   zero_read_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_b_addr == 5'd0) |-> (rd_b_data == '0));

   // R10
   wim_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({32'd0, wim_q} >> NWIN) == 64'd0);

   // R10
   wim_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wim_q == 32'd0) |=> (!ovf && !unf));
endmodule

bind regwin_file regwin_chk #(.NWIN(NWIN), .DW(DW)) chk_i (
   .clk(clk), .rst_n(rst_n), .op(op), .cwp(cwp), .wim_q(wim_q),
   .ovf(ovf), .unf(unf), .fault_win(fault_win),
   .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
   .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
);

// File: tb/regwin_file_tb.sv
`timescale 1ns/1ps
module regwin_file_tb_top;
   localparam int N  = 8;
   localparam int NP = 8 + 16 * N;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op = '0;
   logic        wim_we = 1'b0;
   logic [31:0] wim_wdata = '0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        wr_next_win = 1'b0;
   logic [4:0]  rd_a_addr = '0, rd_b_addr = '0;
   logic [31:0] rd_a_data, rd_b_data, wim_q;
   logic [4:0]  cwp, fault_win;
   logic        ovf, unf;

   always #2.5 clk = ~clk;

   regwin_file #(.NWIN(N), .DW(32)) dut_i (
      .clk(clk), .rst_n(rst_n), .op(op), .wim_we(wim_we), .wim_wdata(wim_wdata),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_next_win(wr_next_win),
      .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
      .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
      .cwp(cwp), .wim_q(wim_q), .ovf(ovf), .unf(unf), .fault_win(fault_win)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   // behavioural model
   logic [31:0] mdl_mem [0:NP-1];
   int          mdl_win = 0;
   logic [31:0] mdl_mask = '0;
   bit          exp_ovf = 0, exp_unf = 0;
   int          exp_fault = 0;

   // storage slot of register r seen from window w, per R2 and R3
   function automatic int slot_of(int w, int r);
      int grp = r / 8;
      int k   = r % 8;
      if (grp == 0) return r;
      if (grp == 1) return slot_of((w + N - 1) % N, 24 + k);
      if (grp == 2) return 8 + 16 * w + k;
      return 8 + 16 * w + 8 + k;
   endfunction

   function automatic logic [31:0] mdl_read(int r);
      if (r == 0) return 32'd0;
      return mdl_mem[slot_of(mdl_win, r)];
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input int o, input bit we, input int wa, input logic [31:0] wd,
                       input bit nw, input bit mwe, input logic [31:0] md,
                       input int ra, input int rb, input string tag);
      int nxt, tgt, dn, up;
      bit f_o, f_u;
      @(negedge clk);
      op = 3'(o); wr_en = we; wr_addr = 5'(wa); wr_data = wd; wr_next_win = nw;
      wim_we = mwe; wim_wdata = md; rd_a_addr = 5'(ra); rd_b_addr = 5'(rb);
      #1;
      check(tag, "cwp", {27'd0, cwp}, 32'(mdl_win));
      check(tag, "wim", wim_q, mdl_mask);
      check(tag, "ovf", {31'd0, ovf}, {31'd0, exp_ovf});
      check(tag, "unf", {31'd0, unf}, {31'd0, exp_unf});
      if (exp_ovf || exp_unf) check(tag, "fault_win", {27'd0, fault_win}, 32'(exp_fault));
      check(tag, "rd_a", rd_a_data, mdl_read(ra));
      check(tag, "rd_b", rd_b_data, mdl_read(rb));
      dn = (mdl_win + N - 1) % N;
      up = (mdl_win + 1) % N;
      nxt = mdl_win; tgt = mdl_win; f_o = 0; f_u = 0;
      case (o)
         1: begin tgt = dn; if (mdl_mask[dn]) f_o = 1; else nxt = dn; end
         3: begin tgt = dn; nxt = dn; end
         2, 4: begin tgt = up; if (mdl_mask[up]) f_u = 1; else nxt = up; end
         default: ;
      endcase
      if (we && wa != 0) mdl_mem[slot_of(nw ? nxt : mdl_win, wa)] = wd;
      if (mwe) mdl_mask = md & 32'h0000_00FF;
      mdl_win = nxt;
      exp_ovf = f_o; exp_unf = f_u;
      if (f_o || f_u) exp_fault = tgt;
      @(posedge clk);
   endtask

   initial begin
      for (int i = 0; i < NP; i++) mdl_mem[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state
      step(0, 0, 0, 0, 0, 0, 0, 9, 30, "R1");
      step(0, 0, 0, 0, 0, 0, 0, 17, 1, "R1");
      // R2 globals and window registers
      step(0, 1, 1, 32'h0000_0011, 0, 0, 0, 0, 0, "R2");
      step(0, 1, 8, 32'h0000_00A0, 0, 0, 0, 1, 0, "R2");
      step(0, 1, 16, 32'h0000_00B0, 0, 0, 0, 8, 1, "R2");
      step(0, 1, 24, 32'h0000_00C0, 0, 0, 0, 16, 8, "R2");
      // R5 write to register 0 discarded
      step(0, 1, 0, 32'hDEAD_BEEF, 0, 0, 0, 24, 0, "R5");
      step(0, 0, 0, 0, 0, 0, 0, 0, 24, "R5");
      // R9 save writes new window's local; R3 caller outs become callee ins
      step(1, 1, 16, 32'h0000_005A, 1, 0, 0, 8, 16, "R9");
      step(0, 0, 0, 0, 0, 0, 0, 24, 16, "R3");
      step(0, 0, 0, 0, 0, 0, 0, 1, 8, "R2");
      // R9 restore writing an out of window 0 (ins of window 7)
      step(2, 1, 8, 32'h0000_0077, 1, 0, 0, 16, 24, "R9");
      step(0, 0, 0, 0, 0, 0, 0, 8, 16, "R9");
      step(1, 0, 0, 0, 0, 0, 0, 8, 24, "R3");
      step(0, 0, 0, 0, 0, 0, 0, 24, 16, "R3");
      // R4 trap entry/return and full wrap
      step(4, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
      step(3, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
      for (int i = 0; i < 9; i++) step(1, 1, 17, 32'(i + 32'h100), 1, 0, 0, 17, 25, "R4");
      for (int i = 0; i < 9; i++) step(2, 0, 0, 0, 0, 0, 0, 17, 9, "R4");
      // R4 unused op codes do nothing
      step(5, 0, 0, 0, 0, 0, 0, 16, 0, "R4");
      step(6, 0, 0, 0, 0, 0, 0, 16, 0, "R4");
      step(7, 0, 0, 0, 0, 0, 0, 16, 0, "R4");
      // R10 mask write with upper garbage; return pointer to 0 first
      while (mdl_win != 0) step(2, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
      step(0, 0, 0, 0, 0, 1, 32'hFFFF_FF40, 0, 0, "R10");
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
      // R6 overflow: 0 -> 7 ok, 7 -> 6 refused; write goes to window 7
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
      step(1, 1, 18, 32'h0000_0F0F, 1, 0, 0, 0, 0, "R6");
      step(0, 0, 0, 0, 0, 0, 0, 18, 0, "R9");
      // R8 trap entry ignores mask
      step(3, 0, 0, 0, 0, 0, 0, 18, 0, "R8");
      step(0, 0, 0, 0, 0, 0, 0, 18, 24, "R8");
      // R7 underflow on restore and trap return
      step(2, 0, 0, 0, 0, 1, 32'h0000_0001, 0, 0, "R7");
      step(2, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
      step(4, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
      step(0, 0, 0, 0, 0, 0, 0, 18, 0, "R7");
      // R10 zero mask never traps
      step(0, 0, 0, 0, 0, 1, 32'h0, 0, 0, "R10");
      for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
      for (int i = 0; i < 10; i++) step(2, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
      // mixed stimulus
      for (int i = 0; i < 600; i++) begin
         int o = $urandom % 6;
         bit mw = ($urandom % 16) == 0;
         logic [31:0] md = (($urandom % 3) == 0) ? 32'h0 : (32'd1 << ($urandom % 10));
         step(o, $urandom % 2 == 1, $urandom % 32, $urandom, $urandom % 2 == 1,
              mw, md, $urandom % 32, $urandom % 32, "R9");
      end
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule